// File: doc/BRIEF.md
# Frame Size Align-and-Clamp Unit

This block turns a requested frame width and height into dimensions that an image rotation engine can accept. Two pixel formats are handled: a two-plane YCbCr 4:2:0 layout and a 32-bit RGB layout. Each format has its own alignment granularity and its own lower and upper size bounds, all set as parameters. Each dimension is first rounded to the nearest alignment boundary. It is then clamped into the format's range, and the bound it is clamped to is itself cleared of its sub-alignment bits.

A request carries a format selector, a width and a height on a valid/ready handshake. The fitted width and height come out of a single output register one cycle after the request is accepted. While the consumer stalls, that register holds its value and the block refuses new requests. Width and height go through identical, independent datapaths that share one limit set picked by the format.

Top module: `frame_size_fitter`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_width and out_height are cleared to zero.
- R2: in_ready is high exactly when the output register is empty or out_ready is high.
- R3: A request accepted at a clock edge (in_valid and in_ready both high) shows its fitted result, with out_valid high, after that edge. If the output is consumed and no new request is accepted, out_valid is low after the edge.
- R4: While out_valid is high and out_ready is low, out_valid, out_width and out_height do not change.
- R5: in_fmt = 0 selects YCbCr 4:2:0. A dimension is rounded by adding 4 and clearing its 3 low bits, with bounds 32 and 32768.
- R6: in_fmt = 1 selects 32-bit RGB. A dimension is rounded by adding 2 and clearing its 2 low bits, with bounds 8 and 8192.
- R7: When the rounded value is below the format's lower bound, the output is that lower bound with its sub-alignment bits cleared.
- R8: When the rounded value is above the format's upper bound, the output is that upper bound with its sub-alignment bits cleared. The rounding addition does not wrap, so an input of 65535 clamps to the upper bound.
- R9: Width and height are fitted independently. One request may have one dimension clamped low while the other is clamped high or passes through.
- R10: Every result of an accepted request is a multiple of its format's alignment and lies within that format's masked bounds.
- R11: With out_ready held high, one request is accepted every cycle and each one produces a result on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_fmt | input | 1 | Pixel format: 0 = YCbCr 4:2:0 two-plane, 1 = 32-bit RGB |
| in_width | input | 16 | Requested width |
| in_height | input | 16 | Requested height |
| out_valid | output | 1 | Fitted result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_width | output | 16 | Fitted width |
| out_height | output | 16 | Fitted height |

## Verification
The clocked properties check the handshake rules on every cycle: when in_ready may be high, that an accepted request always yields out_valid, that a stalled result stays frozen, and that the output drains when it is consumed and nothing new arrives. They also check that every result after an accepted request is aligned and within the bounds of the format that was requested. Only the bench's directed and randomized scenarios can show the exact fitted values: nearest rounding on both sides of a half step, the low and high clamps, the no-wrap case at the top of the input range, and independent treatment of width and height in one request.

// File: rtl/fsz_pkg.sv
// Shared types for the frame size fitter.
// Assumes: limit values fit in 32 bits; alignment is given as log2 of the step.
package fsz_pkg;

    // Pixel format selector; the encoding is visible on the in_fmt port.
    typedef enum logic [0:0] {
        FMT_YUV420_2P = 1'b0,
        FMT_RGB32     = 1'b1
    } pix_fmt_e;

    // One format's limit set: alignment exponent and inclusive bounds.
    typedef struct packed {
        logic [31:0] align_lg;
        logic [31:0] min_v;
        logic [31:0] max_v;
    } size_limit_t;

endpackage

// File: rtl/fsz_limit_sel.sv
// Picks the limit set that belongs to the requested pixel format.
// Assumes: the two limit sets are elaboration-time constants.
module fsz_limit_sel #(
    parameter int unsigned YUV_ALIGN_LG = 3,
    parameter int unsigned YUV_MIN      = 32,
    parameter int unsigned YUV_MAX      = 32768,
    parameter int unsigned RGB_ALIGN_LG = 2,
    parameter int unsigned RGB_MIN      = 8,
    parameter int unsigned RGB_MAX      = 8192
) (
    input  fsz_pkg::pix_fmt_e   fmt,
    output fsz_pkg::size_limit_t lim
);
    import fsz_pkg::*;

    // Format decode into the active limit set.
    always_comb begin
        unique case (fmt)
            FMT_RGB32: begin
                lim.align_lg = 32'(RGB_ALIGN_LG);
                lim.min_v    = 32'(RGB_MIN);
                lim.max_v    = 32'(RGB_MAX);
            end
            default: begin
                lim.align_lg = 32'(YUV_ALIGN_LG);
                lim.min_v    = 32'(YUV_MIN);
                lim.max_v    = 32'(YUV_MAX);
            end
        endcase
    end

endmodule

// File: rtl/fsz_dim_fit.sv
// Fits one dimension: rounds to the nearest alignment step, then clamps into
// the masked bounds of the active limit set. Purely combinational.
// Assumes: the masked upper bound fits in DW bits; align_lg < DW.
// The sum is computed one bit wider than the input so rounding cannot wrap.
module fsz_dim_fit #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0]        req,
    input  fsz_pkg::size_limit_t lim,
    output logic [DW-1:0]        fit
);
    localparam int unsigned SW = DW + 1;

    logic [SW-1:0] step;
    logic [SW-1:0] half;
    logic [SW-1:0] mask;
    logic [SW-1:0] sum;
    logic [SW-1:0] rounded;
    logic [SW-1:0] lo_bound;
    logic [SW-1:0] hi_bound;
    logic [SW-1:0] res;

    // Derive step, half step and alignment mask from the exponent.
    always_comb begin
        step = SW'(1) << lim.align_lg;
        half = step >> 1;
        mask = ~(step - SW'(1));
    end

    // Round to the nearest step in a widened sum.
    always_comb begin
        sum     = {1'b0, req} + half;
        rounded = sum & mask;
    end

    // Masked bounds of the active format.
    always_comb begin
        lo_bound = SW'(lim.min_v) & mask;
        hi_bound = SW'(lim.max_v) & mask;
    end

    // Clamp into the masked range.
    always_comb begin
        if (rounded < lo_bound) begin
            res = lo_bound;
        end else if (rounded > hi_bound) begin
            res = hi_bound;
        end else begin
            res = rounded;
        end
        fit = res[DW-1:0];
    end

endmodule

// File: rtl/fsz_out_stage.sv
// Single output register with a valid/ready handshake on both sides.
// Takes a new payload when empty or when the held one is consumed the same
// cycle; holds the payload unchanged while the consumer stalls.
module fsz_out_stage #(
    parameter int unsigned PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [PW-1:0] din,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] dout
);
    logic          full_q;
    logic [PW-1:0] data_q;
    logic          take;

    // Accept when the register is free or drains this cycle.
    always_comb begin
        in_ready = !full_q || out_ready;
        take     = in_valid && in_ready;
    end

    // Load, drain or hold the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b1;
            data_q <= din;
        end else if (out_ready) begin
            full_q <= 1'b0;
        end
    end

    assign out_valid = full_q;
    assign dout      = data_q;

endmodule

// File: rtl/frame_size_fitter.sv
// Frame size align-and-clamp unit. Selects the format's limit set, fits width
// and height through two identical datapaths and registers the pair.
// Assumes: synchronous active-low reset; default limits give results that fit
// in DW bits (largest bound 32768 with DW = 16).
module frame_size_fitter #(
    parameter int unsigned DW           = 16,
    parameter int unsigned YUV_ALIGN_LG = 3,
    parameter int unsigned YUV_MIN      = 32,
    parameter int unsigned YUV_MAX      = 32768,
    parameter int unsigned RGB_ALIGN_LG = 2,
    parameter int unsigned RGB_MIN      = 8,
    parameter int unsigned RGB_MAX      = 8192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_fmt,
    input  logic [DW-1:0] in_width,
    input  logic [DW-1:0] in_height,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_width,
    output logic [DW-1:0] out_height
);
    import fsz_pkg::*;

    localparam int unsigned NDIM = 2;
    localparam int unsigned PW   = NDIM * DW;

    localparam logic [DW-1:0] YUV_LOW = DW'((1 << YUV_ALIGN_LG) - 1);
    localparam logic [DW-1:0] RGB_LOW = DW'((1 << RGB_ALIGN_LG) - 1);
    localparam logic [DW-1:0] YUV_LO  = DW'(YUV_MIN) & ~YUV_LOW;
    localparam logic [DW-1:0] YUV_HI  = DW'(YUV_MAX) & ~YUV_LOW;
    localparam logic [DW-1:0] RGB_LO  = DW'(RGB_MIN) & ~RGB_LOW;
    localparam logic [DW-1:0] RGB_HI  = DW'(RGB_MAX) & ~RGB_LOW;

    size_limit_t              lim;
    logic [NDIM-1:0][DW-1:0]  req;
    logic [NDIM-1:0][DW-1:0]  fit;
    logic [PW-1:0]            held;

    fsz_limit_sel #(
        .YUV_ALIGN_LG (YUV_ALIGN_LG),
        .YUV_MIN      (YUV_MIN),
        .YUV_MAX      (YUV_MAX),
        .RGB_ALIGN_LG (RGB_ALIGN_LG),
        .RGB_MIN      (RGB_MIN),
        .RGB_MAX      (RGB_MAX)
    ) u_lim (
        .fmt (pix_fmt_e'(in_fmt)),
        .lim (lim)
    );

    // Gather both dimensions so one generate loop builds their datapaths.
    always_comb begin
        req[0] = in_width;
        req[1] = in_height;
    end

    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        fsz_dim_fit #(.DW(DW)) u_fit (
            .req (req[d]),
            .lim (lim),
            .fit (fit[d])
        );
    end

    fsz_out_stage #(.PW(PW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .din       (fit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .dout      (held)
    );

    assign out_width  = held[DW-1:0];
    assign out_height = held[PW-1:DW];

    // R2
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);

    // R2
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R3
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_width) && $stable(out_height)));

    // R10
    yuv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_fmt) |=>
            (((out_width & YUV_LOW) == '0) && ((out_height & YUV_LOW) == '0) &&
             (out_width >= YUV_LO) && (out_width <= YUV_HI) &&
             (out_height >= YUV_LO) && (out_height <= YUV_HI)));

    // R10
    rgb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_fmt) |=>
            (((out_width & RGB_LOW) == '0) && ((out_height & RGB_LOW) == '0) &&
             (out_width >= RGB_LO) && (out_width <= RGB_HI) &&
             (out_height >= RGB_LO) && (out_height <= RGB_HI)));

endmodule

// File: tb/frame_size_fitter_tb.sv
module frame_size_fitter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_fmt = 1'b0;
    logic [15:0] in_width = '0;
    logic [15:0] in_height = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_width;
    logic [15:0] out_height;

    int n_chk = 0;
    int n_fail = 0;
    bit monitor_on = 1'b0;
    bit done = 1'b0;

    // Model state
    bit m_valid = 1'b0;
    int m_w = 0;
    int m_h = 0;

    always #5 clk = ~clk;

    frame_size_fitter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_fmt     (in_fmt),
        .in_width   (in_width),
        .in_height  (in_height),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_width  (out_width),
        .out_height (out_height)
    );

    // Behavioural fit: nearest multiple of the step, then clamp (R5..R8).
    function automatic int ref_fit(bit fmt, int v);
        int step, lo, hi, r;
        step = fmt ? 4 : 8;
        lo   = fmt ? 8 : 32;
        hi   = fmt ? 8192 : 32768;
        r = ((v + step / 2) / step) * step;
        if (r < lo) r = lo;
        else if (r > hi) r = hi;
        return r;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of the output register.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_w <= 0;
            m_h <= 0;
        end else if (in_valid && (!m_valid || out_ready)) begin
            m_valid <= 1'b1;
            m_w <= ref_fit(in_fmt, int'(in_width));
            m_h <= ref_fit(in_fmt, int'(in_height));
        end else if (out_ready) begin
            m_valid <= 1'b0;
        end
    end

    // Cycle-by-cycle comparison against the model (R2, R3, R4).
    always @(negedge clk) begin
        if (monitor_on && rst_n) begin
            chk(in_ready == (!m_valid || out_ready), "R2 in_ready", int'(in_ready),
                int'(!m_valid || out_ready));
            chk(out_valid == m_valid, "R3 out_valid", int'(out_valid), int'(m_valid));
            if (m_valid) begin
                chk(int'(out_width) == m_w, "R3 out_width", int'(out_width), m_w);
                chk(int'(out_height) == m_h, "R3 out_height", int'(out_height), m_h);
            end
        end
    end

    // Drive one request, then check the result on the next cycle.
    task automatic probe(bit fmt, int w, int h, int ew, int eh, string tag);
        @(posedge clk); #2;
        in_valid  = 1'b1;
        in_fmt    = fmt;
        in_width  = 16'(w);
        in_height = 16'(h);
        out_ready = 1'b1;
        @(posedge clk); #2;
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid, {tag, " valid"}, int'(out_valid), 1);
        chk(int'(out_width) == ew, {tag, " width"}, int'(out_width), ew);
        chk(int'(out_height) == eh, {tag, " height"}, int'(out_height), eh);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
        chk(out_width == '0, "R1 out_width", int'(out_width), 0);
        chk(out_height == '0, "R1 out_height", int'(out_height), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        monitor_on = 1'b1;

        // R5: YCbCr rounding on both sides of the half step
        probe(1'b0, 100, 99, 104, 96, "R5 yuv round");
        probe(1'b0, 101, 35, 104, 32, "R5 yuv round2");
        // R6: RGB rounding
        probe(1'b1, 101, 102, 100, 104, "R6 rgb round");
        probe(1'b1, 9, 13, 8, 12, "R6 rgb round2");
        // R7: below the lower bound
        probe(1'b0, 27, 0, 32, 32, "R7 yuv low");
        probe(1'b1, 5, 0, 8, 8, "R7 rgb low");
        // R8: above the upper bound, no wrap at 65535
        probe(1'b0, 32772, 65535, 32768, 32768, "R8 yuv high");
        probe(1'b1, 8194, 65535, 8192, 8192, "R8 rgb high");
        probe(1'b1, 8193, 65534, 8192, 8192, "R8 rgb high2");
        // R9: independent dimensions
        probe(1'b0, 3, 40000, 32, 32768, "R9 yuv split");
        probe(1'b1, 65535, 640, 8192, 640, "R9 rgb split");

        // R3: drain with no new request
        @(posedge clk); #2;
        @(negedge clk);
        chk(!out_valid, "R3 drain", int'(out_valid), 0);

        // R4: stall holds the result and blocks input
        @(posedge clk); #2;
        out_ready = 1'b0;
        in_valid = 1'b1; in_fmt = 1'b1; in_width = 16'd333; in_height = 16'd77;
        @(posedge clk); #2;
        in_width = 16'd1000; in_height = 16'd2000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(int'(out_width) == 332, "R4 hold width", int'(out_width), 332);
            chk(int'(out_height) == 76, "R4 hold height", int'(out_height), 76);
            chk(!in_ready, "R4 blocked", int'(in_ready), 0);
        end
        @(posedge clk); #2;
        out_ready = 1'b1;
        @(posedge clk); #2;
        in_valid = 1'b0;
        @(negedge clk);
        chk(int'(out_width) == 1000, "R4 next width", int'(out_width), 1000);

        // R11: back-to-back stream with out_ready high
        @(posedge clk); #2;
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1; in_fmt = i[0];
            in_width = 16'(50 + 17 * i); in_height = 16'(900 - 31 * i);
            @(posedge clk); #2;
            chk(out_valid, "R11 stream", int'(out_valid), 1);
            chk(int'(out_width) == ref_fit(i[0], 50 + 17 * i), "R11 width",
                int'(out_width), ref_fit(i[0], 50 + 17 * i));
        end
        in_valid = 1'b0;

        // Randomized traffic checked by the model (R10 via assertions)
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #2;
            in_valid  = ($urandom % 4) != 0;
            in_fmt    = $urandom % 2;
            in_width  = 16'($urandom);
            in_height = (($urandom % 2) != 0) ? 16'($urandom % 200) : 16'($urandom);
            out_ready = ($urandom % 3) != 0;
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R3 final drain", int'(out_valid), 0);

        // R1: reset mid-stream clears the output
        @(posedge clk); #2;
        in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk); #2;
        monitor_on = 1'b0;
        rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); #2;
        @(negedge clk);
        chk(!out_valid, "R1 reset again", int'(out_valid), 0);
        chk(out_width == '0, "R1 reset width", int'(out_width), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule